// File: doc/BRIEF.md
# Segment Selector Capture Port

This block sits at the edge of a waveform playback engine and lets an external controller pick which stored waveform segment plays next. A 16-bit segment identifier arrives on a parallel bus together with a qualifier line. The qualifier line is asynchronous to the local clock, so it passes through a synchronizer first. The bus is delayed by the same number of stages, so the identifier stays aligned with its qualifier. Each low-to-high transition of the qualifier, seen while segment mode is active, produces a one-cycle selection strobe. The strobe carries the identifier that was on the bus when the qualifier rose. A qualifier that stays high produces no further strobes.

The block also holds the port's operating state: an IQ streaming enable, a segment streaming enable and a test enable. These are driven by single-cycle commands. The two streaming modes exclude each other. A command to enable one streaming mode while the other is on is refused and sets a sticky error flag. While test is enabled, the synchronized bus value and qualifier level are mirrored onto diagnostic outputs.

Top module: `seg_select_port`

## Requirements
- R1: After reset, iq_mode, seg_mode, test_mode, mode_err, sel_strobe, diag_valid and diag_addr are all 0.
- R2: When cmd_valid is 1, cmd_op selects the action for that cycle: 1 sets IQ mode on, 2 sets IQ mode off, 3 sets segment mode on, 4 sets segment mode off, 5 sets test on, 6 sets test off. The mode output changes at the same clock edge.
- R3: While seg_mode is 1, a rising edge on seg_vld produces sel_strobe high for exactly one cycle, with sel_id equal to the seg_id value present when seg_vld rose. The strobe is visible after the third rising clock edge that follows the change on the inputs.
- R4: No strobe is produced while seg_vld stays high, including when seg_vld was already high when segment mode was enabled.
- R5: No strobe is produced for a seg_vld rising edge while seg_mode is 0.
- R6: A command to turn on IQ mode while segment mode is on, or to turn on segment mode while IQ mode is on, is ignored and sets mode_err. mode_err stays set until reset.
- R7: iq_mode and seg_mode are never both 1.
- R8: While test_mode is 1, diag_addr and diag_valid follow seg_id and seg_vld three clock edges later. While test_mode is 0, both outputs are 0.
- R9: cmd_op values 0 and 7, and any command with cmd_valid at 0, change no mode and do not set mode_err.
- R10: A change of seg_id while seg_vld stays high produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Mode command qualifier |
| cmd_op | input | 3 | Mode command code |
| seg_vld | input | 1 | Segment identifier qualifier, asynchronous |
| seg_id | input | 16 | Segment identifier bus |
| iq_mode | output | 1 | IQ streaming enabled |
| seg_mode | output | 1 | Segment streaming enabled |
| test_mode | output | 1 | Test mirror enabled |
| mode_err | output | 1 | Sticky refused-command flag |
| sel_strobe | output | 1 | One-cycle segment selection strobe |
| sel_id | output | 16 | Selected segment identifier |
| diag_valid | output | 1 | Mirrored qualifier level |
| diag_addr | output | 16 | Mirrored identifier bus |

## Verification
The capture path is driven with isolated qualifier pulses carrying distinct identifiers. This shows that the strobe is tied to edges and carries the right identifier. A long high level with the bus changing underneath separates edge capture from level capture. A qualifier that is already high when segment mode is enabled separates edge detection from arming on mode entry. Pulses sent with segment mode off show that the mode actually gates capture. On the control side, enable commands arrive while the other streaming mode is on, and reserved codes are issued, to separate refusal from silent acceptance. The mirror is checked with test on and again with test off.

// File: rtl/seg_port_pkg.sv
package seg_port_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_IQ_ON    = 3'd1,
    OP_IQ_OFF   = 3'd2,
    OP_SEG_ON   = 3'd3,
    OP_SEG_OFF  = 3'd4,
    OP_TEST_ON  = 3'd5,
    OP_TEST_OFF = 3'd6,
    OP_RSVD     = 3'd7
  } mode_op_e;

  // An enable of one streaming mode is refused while the other is on.
  function automatic logic op_refused(input mode_op_e op, input logic iq_on, input logic seg_on);
    return ((op == OP_IQ_ON) && seg_on) || ((op == OP_SEG_ON) && iq_on);
  endfunction

  function automatic logic is_rise(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction
endpackage

// File: rtl/seg_mode_ctl.sv
module seg_mode_ctl
  import seg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  output logic       iq_on,
  output logic       seg_on,
  output logic       test_on,
  output logic       err_flag,
  output logic       refuse_ev
);
  mode_op_e op;
  assign op        = mode_op_e'(cmd_op);
  assign refuse_ev = cmd_valid && op_refused(op, iq_on, seg_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iq_on    <= 1'b0;
      seg_on   <= 1'b0;
      test_on  <= 1'b0;
      err_flag <= 1'b0;
    end else if (cmd_valid) begin
      if (refuse_ev) err_flag <= 1'b1;
      else begin
        case (op)
          OP_IQ_ON:    iq_on   <= 1'b1;
          OP_IQ_OFF:   iq_on   <= 1'b0;
          OP_SEG_ON:   seg_on  <= 1'b1;
          OP_SEG_OFF:  seg_on  <= 1'b0;
          OP_TEST_ON:  test_on <= 1'b1;
          OP_TEST_OFF: test_on <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(iq_on && seg_on)); // R7
  AST_REFUSE_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_ev |=> err_flag && $stable(iq_on) && $stable(seg_on)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R6
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(iq_on) && $stable(seg_on) && $stable(test_on) && $stable(err_flag)); // R9
endmodule

// File: rtl/seg_edge_capture.sv
module seg_edge_capture
  import seg_port_pkg::*;
#(
  parameter int ID_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            vld_async,
  input  logic [ID_W-1:0] id_in,
  output logic            vld_sync,
  output logic [ID_W-1:0] id_sync,
  output logic            rise_ev,
  output logic            strobe,
  output logic [ID_W-1:0] id_out
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] vsh;
  logic [ID_W-1:0]        idsh [SYNC_STAGES];
  logic                   vprev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vsh[0]  <= 1'b0;
      idsh[0] <= '0;
    end else begin
      vsh[0]  <= vld_async;
      idsh[0] <= id_in;
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vsh[g]  <= 1'b0;
        idsh[g] <= '0;
      end else begin
        vsh[g]  <= vsh[g-1];
        idsh[g] <= idsh[g-1];
      end
    end
  end

  assign vld_sync = vsh[LAST];
  assign id_sync  = idsh[LAST];
  assign rise_ev  = is_rise(vld_sync, vprev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vprev  <= 1'b0;
      strobe <= 1'b0;
      id_out <= '0;
    end else begin
      vprev  <= vld_sync;
      strobe <= rise_ev && arm;
      if (rise_ev && arm) id_out <= id_sync;
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R3
  AST_STROBE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(arm)); // R5
  AST_NO_STROBE_ON_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_sync && vprev) |=> !strobe); // R4
endmodule

// File: rtl/seg_diag_mirror.sv
module seg_diag_mirror #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            vld_in,
  input  logic [ID_W-1:0] id_in,
  output logic            diag_vld,
  output logic [ID_W-1:0] diag_id
);
  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      diag_vld <= 1'b0;
      diag_id  <= '0;
    end else begin
      diag_vld <= vld_in;
      diag_id  <= id_in;
    end
  end

  AST_DIAG_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!diag_vld && diag_id == '0)); // R8
endmodule

// File: rtl/seg_select_port.sv
module seg_select_port #(
  parameter int ID_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic            seg_vld,
  input  logic [ID_W-1:0] seg_id,
  output logic            iq_mode,
  output logic            seg_mode,
  output logic            test_mode,
  output logic            mode_err,
  output logic            sel_strobe,
  output logic [ID_W-1:0] sel_id,
  output logic            diag_valid,
  output logic [ID_W-1:0] diag_addr
);
  logic            refuse_ev;
  logic            rise_ev;
  logic            vld_sync;
  logic [ID_W-1:0] id_sync;

  seg_mode_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .iq_on(iq_mode), .seg_on(seg_mode), .test_on(test_mode),
    .err_flag(mode_err), .refuse_ev(refuse_ev)
  );

  seg_edge_capture #(.ID_W(ID_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .arm(seg_mode), .vld_async(seg_vld), .id_in(seg_id),
    .vld_sync(vld_sync), .id_sync(id_sync), .rise_ev(rise_ev),
    .strobe(sel_strobe), .id_out(sel_id)
  );

  seg_diag_mirror #(.ID_W(ID_W)) u_diag (
    .clk(clk), .rst_n(rst_n), .en(test_mode), .vld_in(vld_sync), .id_in(id_sync),
    .diag_vld(diag_valid), .diag_id(diag_addr)
  );

  AST_STROBE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_strobe |-> $past(rise_ev)); // R3
  AST_ID_HELD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_strobe |-> $stable(sel_id)); // R10
endmodule

// File: tb/seg_select_port_tb_top.sv
module seg_select_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        seg_vld = 1'b0;
  logic [15:0] seg_id = 16'h0;
  logic        iq_mode, seg_mode, test_mode, mode_err, sel_strobe, diag_valid;
  logic [15:0] sel_id, diag_addr;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  logic [15:0] exp_q [$];

  always #2.5 clk = ~clk;

  seg_select_port dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .seg_vld(seg_vld), .seg_id(seg_id), .iq_mode(iq_mode), .seg_mode(seg_mode),
    .test_mode(test_mode), .mode_err(mode_err), .sel_strobe(sel_strobe),
    .sel_id(sel_id), .diag_valid(diag_valid), .diag_addr(diag_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: pulse the qualifier with an identifier; push expectation when segment mode is on.
  task automatic pulse(input logic [15:0] id, input int hi, input logic expect_cap);
    @(negedge clk);
    seg_id  = id;
    seg_vld = 1'b1;
    if (expect_cap) exp_q.push_back(id);
    idle(hi);
    seg_vld = 1'b0;
    idle(4);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (iq_mode && seg_mode) begin
        errors++;
        $display("FAIL R7 actual=both expected=exclusive");
      end
      if (sel_strobe) begin
        strobes++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R4/R5 actual=unexpected strobe id %0h expected=none", sel_id);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check("R3 id", {16'h0, sel_id}, {16'h0, e});
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 modes", {iq_mode, seg_mode, test_mode, mode_err}, 0);
    check("R1 outs", {sel_strobe, diag_valid, diag_addr}, 0);

    cmd(3'd1);
    check("R2 iq on", iq_mode, 1);
    cmd(3'd3);
    check("R6 seg refused", seg_mode, 0);
    check("R6 err set", mode_err, 1);
    cmd(3'd2);
    check("R2 iq off", iq_mode, 0);
    check("R6 err sticky", mode_err, 1);
    cmd(3'd3);
    check("R2 seg on", seg_mode, 1);
    cmd(3'd1);
    check("R6 iq refused", {iq_mode, seg_mode}, 2'b01);

    cmd(3'd7);
    cmd(3'd0);
    check("R9 reserved/nop", {iq_mode, seg_mode, test_mode}, 3'b010);

    // R3 latency: strobe after third rising edge.
    @(negedge clk);
    seg_id = 16'hA5C3;
    seg_vld = 1'b1;
    exp_q.push_back(16'hA5C3);
    idle(2);
    check("R3 not early", sel_strobe, 0);
    idle(1);
    check("R3 latency", {sel_strobe, sel_id}, {1'b1, 16'hA5C3});
    idle(1);
    check("R3 one cycle", sel_strobe, 0);
    seg_vld = 1'b0;
    idle(4);

    pulse(16'h0001, 1, 1'b1);
    pulse(16'hFFFF, 3, 1'b1);
    pulse(16'h1234, 2, 1'b1);

    // R4/R10: long high with bus changing.
    s0 = strobes;
    @(negedge clk);
    seg_id = 16'h4444; seg_vld = 1'b1;
    exp_q.push_back(16'h4444);
    idle(5);
    seg_id = 16'h5555;
    idle(6);
    check("R10 single strobe on long high", strobes - s0, 1);
    seg_vld = 1'b0;
    idle(4);

    // R5: seg mode off, pulses ignored.
    cmd(3'd4);
    s0 = strobes;
    pulse(16'h7777, 2, 1'b0);
    check("R5 no strobe when off", strobes - s0, 0);

    // R4: valid already high at enable.
    @(negedge clk);
    seg_id = 16'h8888; seg_vld = 1'b1;
    idle(5);
    cmd(3'd3);
    idle(6);
    check("R4 high at enable", strobes - s0, 0);
    seg_vld = 1'b0;
    idle(4);
    pulse(16'h9999, 2, 1'b1);

    // R8 mirror.
    cmd(3'd5);
    check("R2 test on", test_mode, 1);
    @(negedge clk);
    seg_id = 16'hBEEF; seg_vld = 1'b1;
    exp_q.push_back(16'hBEEF);
    idle(3);
    check("R8 mirror", {diag_valid, diag_addr}, {1'b1, 16'hBEEF});
    seg_vld = 1'b0;
    idle(3);
    check("R8 mirror low", diag_valid, 0);
    cmd(3'd6);
    seg_vld = 1'b1;
    exp_q.push_back(16'hBEEF);
    idle(5);
    check("R8 quiet off", {diag_valid, diag_addr}, 0);
    seg_vld = 1'b0;
    idle(4);

    check("R3 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule